// File: doc/BRIEF.md
# Display Object Priority Resolver

This block picks the one 8-bit color-luminance code shown at each color clock. The inputs are active flags for the current pixel: four players, four missiles and four playfield types. Background is shown when no object is active. Nine color-luminance registers and one priority control word are loaded over a small write bus.

The priority word chooses one of four stacking orders. The order is applied to four object groups: players 0/1, players 2/3, playfields 0/1 and playfields 2/3. If several ordering bits are set at once and they name different front groups for a pixel, that pixel is forced to black.

Two further bits change how objects are grouped. One turns the four missiles into a fifth player that takes playfield 3's color and rank. The other ORs the colors of each player pair wherever both players of the pair are on.

The result is registered. It appears one color clock after the flags that produced it.

Top module: `pix_prio_mux`

## Requirements
- R1: A write with `wr_addr` 0x12..0x1A loads the color registers for player 0..3, then playfield 0..3, then background. Address 0x1B loads the priority word. A write to any other address changes nothing. Bit 0 of a color byte is dropped, so `pix_out[0]` is always 0.
- R2: `pix_out` is registered. The code for the flags present before a rising edge appears after that edge. While reset is asserted and after it, `pix_out` is 0x00 and every register is zero.
- R3: When no player, missile or playfield flag is set, the background color is shown.
- R4: Priority nibble (word bits 3:0) 0001 orders objects front to back as P0, P1, P2, P3, PF0, PF1, PF2, PF3, background.
- R5: Nibble 0010 orders objects as P0, P1, PF0, PF1, PF2, PF3, P2, P3.
- R6: Nibble 0100 places PF0..PF3 in front of P0..P3.
- R7: Nibble 1000 orders objects as PF0, PF1, P0, P1, P2, P3, PF2, PF3.
- R8: Nibble 0000 behaves as 0001.
- R9: With more than one nibble bit set, a pixel is black (0x00) when the set orderings disagree on which group is in front. Otherwise the shared winner is shown. For example, with 1010, P0 over PF0 is black, P2 over PF2 is black, and P0 over PF2 shows P0.
- R10: With word bit 4 set, any active missile is shown as playfield 3, with playfield 3's color and rank.
- R11: With word bit 4 clear, missile n is shown with the color and rank of player n.
- R12: With word bit 5 set, a pixel where both P0 and P1 (or both P2 and P3) are active shows the bitwise OR of the two players' colors.
- R13: Within a group, the lower-numbered object wins: P0 over P1 when bit 5 is clear, and PF0 over PF1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Color clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| plr_on | input | 4 | Player active flags, bit n = player n |
| msl_on | input | 4 | Missile active flags, bit n = missile n |
| pf_on | input | 4 | Playfield active flags, bit n = playfield type n |
| pix_out | output | 8 | Color-luminance code of the pixel |

## Verification
Every result is registered on the next edge, so a wrong group winner, a missed conflict or a stale color register shows up at `pix_out` exactly one clock after the offending flags. Each scenario therefore pairs two overlapping objects whose written colors are all distinct. This means a wrong ordering or grouping appears as a specific wrong byte, not as a lucky match. A corrupted color or priority register keeps showing on every later pixel that uses it, until that register is rewritten.

// File: rtl/pix_prio_mux.sv
module pix_prio_mux #(
  parameter int CW   = 8,
  parameter int AW   = 5,
  parameter logic [4:0] BASE = 5'h12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic [3:0]    plr_on,
  input  logic [3:0]    msl_on,
  input  logic [3:0]    pf_on,
  output logic [CW-1:0] pix_out
);
  localparam int NCOL = 9;
  localparam int BGI  = NCOL - 1;
  localparam logic [AW-1:0] PRIO_A = AW'(BASE) + AW'(NCOL);

  logic [CW-1:1] col_q [NCOL];
  logic [5:0]    prio_q;

  for (genvar i = 0; i < NCOL; i++) begin : g_col
    always_ff @(posedge clk)
      if (!rst_n) col_q[i] <= '0;
      else if (wr_en && wr_addr == AW'(BASE) + AW'(i)) col_q[i] <= wr_data[CW-1:1];
  end

  always_ff @(posedge clk)
    if (!rst_n) prio_q <= '0;
    else if (wr_en && wr_addr == PRIO_A) prio_q <= wr_data[5:0];

  wire fifth = prio_q[4];
  wire multi = prio_q[5];
  wire [3:0] nib = (prio_q[3:0] == 4'b0000) ? 4'b0001 : prio_q[3:0];

  wire [3:0] p_act  = plr_on | (fifth ? 4'b0000 : msl_on);
  wire [3:0] pf_act = {pf_on[3] | (fifth & |msl_on), pf_on[2:0]};

  // group index: 0 = P0/P1, 1 = P2/P3, 2 = PF0/PF1, 3 = PF2/PF3
  wire [3:0] grp = {|pf_act[3:2], |pf_act[1:0], |p_act[3:2], |p_act[1:0]};

  function automatic logic [3:0] front(input logic [3:0] a,
                                       input int o0, input int o1, input int o2, input int o3);
    logic [3:0] r;
    r = '0;
    if      (a[o0]) r[o0] = 1'b1;
    else if (a[o1]) r[o1] = 1'b1;
    else if (a[o2]) r[o2] = 1'b1;
    else if (a[o3]) r[o3] = 1'b1;
    return r;
  endfunction

  logic [3:0] win [4];
  assign win[0] = front(grp, 0, 1, 2, 3);
  assign win[1] = front(grp, 0, 2, 3, 1);
  assign win[2] = front(grp, 2, 3, 0, 1);
  assign win[3] = front(grp, 2, 0, 1, 3);

  logic [3:0] agree;
  always_comb begin
    agree = '0;
    for (int k = 0; k < 4; k++)
      if (nib[k]) agree = agree | win[k];
  end

  logic [CW-1:1] c_a, c_b, c_c, c_d, pick;
  always_comb begin
    if (p_act[0]) c_a = (multi && p_act[1]) ? (col_q[0] | col_q[1]) : col_q[0];
    else          c_a = col_q[1];
    if (p_act[2]) c_b = (multi && p_act[3]) ? (col_q[2] | col_q[3]) : col_q[2];
    else          c_b = col_q[3];
    c_c = pf_act[0] ? col_q[4] : col_q[5];
    c_d = pf_act[2] ? col_q[6] : col_q[7];
    unique case (agree)
      4'b0000: pick = col_q[BGI];
      4'b0001: pick = c_a;
      4'b0010: pick = c_b;
      4'b0100: pick = c_c;
      4'b1000: pick = c_d;
      default: pick = '0;
    endcase
  end

  always_ff @(posedge clk)
    if (!rst_n) pix_out <= '0;
    else        pix_out <= {pick, 1'b0};

  // R3
  bg_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (plr_on == 4'b0 && msl_on == 4'b0 && pf_on == 4'b0) |=> pix_out == {$past(col_q[BGI]), 1'b0});

  // R9
  conflict_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_q[3:0] == 4'b1010 && plr_on == 4'b0001 && msl_on == 4'b0 && pf_on == 4'b0001) |=> pix_out == '0);

  // R10
  fifth_plr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_q[4] && plr_on == 4'b0 && pf_on == 4'b0 && msl_on != 4'b0) |=> pix_out == {$past(col_q[7]), 1'b0});

  // R12
  pair_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_q[5] && prio_q[3:0] == 4'b0001 && plr_on == 4'b0011 && msl_on == 4'b0 && pf_on == 4'b0)
      |=> pix_out == {$past(col_q[0] | col_q[1]), 1'b0});

  // R1
  lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> pix_out[0] == 1'b0);
endmodule

// File: tb/pix_prio_mux_bench.sv
`timescale 1ns/1ps
module pix_prio_mux_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] plr_on = '0, msl_on = '0, pf_on = '0;
  logic [7:0] pix_out;
  int checks = 0, failures = 0;
  logic [7:0] colr [9] = '{8'h21, 8'h44, 8'h63, 8'h86, 8'hA9, 8'hCA, 8'hED, 8'h3F, 8'h05};

  always #4 clk = ~clk;

  pix_prio_mux u_pix_prio_mux (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .plr_on(plr_on), .msl_on(msl_on), .pf_on(pf_on), .pix_out(pix_out));

  function automatic logic [7:0] c(input int i);
    return colr[i] & 8'hFE;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic show(input string req, input logic [3:0] p, input logic [3:0] m,
                      input logic [3:0] f, input logic [7:0] exp);
    plr_on = p; msl_on = m; pf_on = f;
    @(posedge clk); @(negedge clk);
    chk(req, pix_out, exp);
    plr_on = '0; msl_on = '0; pf_on = '0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R2 in reset", pix_out, 8'h00);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 after reset", pix_out, 8'h00);
  endtask

  task automatic t_regs();
    for (int i = 0; i < 9; i++) wr(5'h12 + 5'(i), colr[i]);
    wr(5'h1B, 8'h01);
    show("R3 background, R1 bit0 dropped", 4'b0, 4'b0, 4'b0, c(8));
    wr(5'h11, 8'hFF);
    wr(5'h1C, 8'hFF);
    show("R1 stray address ignored (P0)", 4'b0001, 4'b0, 4'b0, c(0));
    show("R1 stray address ignored (bg)", 4'b0, 4'b0, 4'b0, c(8));
  endtask

  task automatic t_latency();
    plr_on = 4'b0100;
    #1 chk("R2 no change before edge", pix_out, c(8));
    @(posedge clk); @(negedge clk);
    chk("R2 one-clock latency", pix_out, c(2));
    plr_on = '0;
  endtask

  task automatic t_orders();
    wr(5'h1B, 8'h01);
    show("R4 P3 over PF0", 4'b1000, 4'b0, 4'b0001, c(3));
    show("R4 PF2 over PF3", 4'b0, 4'b0, 4'b1100, c(6));
    wr(5'h1B, 8'h02);
    show("R5 PF3 over P2", 4'b0100, 4'b0, 4'b1000, c(7));
    show("R5 P1 over PF0", 4'b0010, 4'b0, 4'b0001, c(1));
    wr(5'h1B, 8'h04);
    show("R6 PF3 over P0", 4'b0001, 4'b0, 4'b1000, c(7));
    wr(5'h1B, 8'h08);
    show("R7 PF1 over P0", 4'b0001, 4'b0, 4'b0010, c(5));
    show("R7 P3 over PF2", 4'b1000, 4'b0, 4'b0100, c(3));
    wr(5'h1B, 8'h00);
    show("R8 zero nibble, P3 over PF0", 4'b1000, 4'b0, 4'b0001, c(3));
  endtask

  task automatic t_conflict();
    wr(5'h1B, 8'h0A);
    show("R9 P0 over PF0 black", 4'b0001, 4'b0, 4'b0001, 8'h00);
    show("R9 P2 over PF2 black", 4'b0100, 4'b0, 4'b0100, 8'h00);
    show("R9 P0 over PF2 agrees", 4'b0001, 4'b0, 4'b0100, c(0));
  endtask

  task automatic t_missiles();
    wr(5'h1B, 8'h11);
    show("R10 missile as PF3", 4'b0, 4'b0100, 4'b0, c(7));
    show("R10 P1 over fifth player", 4'b0010, 4'b0001, 4'b0, c(1));
    wr(5'h1B, 8'h01);
    show("R11 missile 2 as P2", 4'b0, 4'b0100, 4'b0, c(2));
    show("R11 missile 1 over PF0", 4'b0, 4'b0010, 4'b0001, c(1));
  endtask

  task automatic t_pairs();
    wr(5'h1B, 8'h21);
    show("R12 P0|P1", 4'b0011, 4'b0, 4'b0, c(0) | c(1));
    show("R12 P2|P3", 4'b1100, 4'b0, 4'b0, c(2) | c(3));
    wr(5'h1B, 8'h01);
    show("R13 P0 over P1", 4'b0011, 4'b0, 4'b0, c(0));
    show("R13 PF0 over PF1", 4'b0, 4'b0, 4'b0011, c(4));
  endtask

  initial begin
    t_reset();
    t_regs();
    t_latency();
    t_orders();
    t_conflict();
    t_missiles();
    t_pairs();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule